// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Feedback Divider

This block divides a fast input clock by an integer programmed as two fields: a period count M and a swallow count A. A small prescaler normally divides by 8. For the first A of its output periods in each divide cycle it divides by 9, which adds one input clock to each of those periods. The M counter counts M prescaler periods and then closes the cycle, so one full cycle lasts M×8+A input clocks. M is 8 bits wide and A is 3 bits wide, which allows moduli from 8 up to 2047.

At the end of every complete cycle the block emits a pulse one input clock wide, which goes to a phase detector. New M and A values are sampled only at cycle boundaries, so the programming inputs can change at any time without producing a short or torn cycle. If A is not smaller than M, the swallow periods cannot fit inside one cycle. The block then reports the setting as invalid and produces no pulses until a usable setting is applied. All logic runs on the input clock. The reset input is asynchronous and active low, and its release is synchronised inside the block.

Top module: `fbdiv_dual_mod`

## Requirements
- R1: While `rst_n` is low, `fb_pulse` and `cfg_bad` are 0. After `rst_n` rises, the first `fb_pulse` appears M×8+A+3 input clocks later: two clocks for release synchronisation, one clock to capture the setting, then one full cycle that starts with its swallow periods.
- R2: With a valid setting, consecutive `fb_pulse` assertions are exactly M×8+A input clocks apart, where M is the unsigned value of `mod_m` and A is the unsigned value of `swl_a`.
- R3: With A=0, the spacing between pulses is exactly M×8.
- R4: With A=1, exactly one prescaler period per cycle is stretched, so the spacing is M×8+1.
- R5: Each `fb_pulse` lasts exactly one input clock.
- R6: A value applied to `mod_m` or `swl_a` is captured only in the clock that ends a cycle. The cycle already in progress keeps its old length, including when the change arrives partway through that cycle.
- R7: A captured setting with A ≥ M (M=0 included) drives `cfg_bad` to 1 in the same clock as the pulse that ended the previous cycle. After that, `fb_pulse` stays 0. While the block is idle it re-samples the inputs every clock. Once a valid setting is applied, `cfg_bad` returns to 0 one clock later, and the first pulse follows M×8+A clocks after that capture.
- R8: The extreme settings work: M=1, A=0 gives a spacing of 8, and M=255, A=7 gives a spacing of 2047.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| mod_m | input | 8 | Prescaler periods per divide cycle (M) |
| swl_a | input | 3 | Number of stretched (divide-by-9) periods per cycle (A) |
| fb_pulse | output | 1 | One-clock pulse at the end of each complete cycle |
| cfg_bad | output | 1 | High while the captured setting has A ≥ M |

## Verification
Two events can fall in the same clock: the end of a cycle and the capture of a setting that turns out to be invalid. The bench sets A ≥ M just after a pulse, so the invalid values are picked up at the end of the following cycle. At that clock it expects `fb_pulse` and `cfg_bad` to be high together, and afterwards it expects no further pulses. A second collision is a mid-cycle change of M and A. The bench judges it by checking that the interval in progress keeps its old length and that the new length appears only in the cycle after.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;

  // Default geometry of the divider
  localparam int FB_PRE_BASE = 8;  // prescaler base modulus
  localparam int FB_MOD_W    = 8;  // width of the period count
  localparam int FB_SWL_W    = 3;  // width of the swallow count
  localparam int FB_SYNC_LEN = 2;  // reset release synchroniser depth

  // Run state of the divider
  typedef enum logic {
    FB_IDLE = 1'b0,
    FB_RUN  = 1'b1
  } fb_state_e;

endpackage

// File: rtl/fbdiv_rst_sync.sv
module fbdiv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  // Shift a one in behind the released reset
  generate
    if (STAGES == 1) begin : g_single
      always_comb sync_d = 1'b1;
    end else begin : g_chain
      always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/fbdiv_prescaler.sv
module fbdiv_prescaler #(
  parameter int BASE = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,          // count input clocks
  input  logic restart,     // force the phase back to zero
  input  logic swallow,     // divide by BASE+1 for this period
  output logic period_end   // last input clock of a prescaler period
);

  localparam int CW = $clog2(BASE + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic [CW-1:0] last_idx;

  // A stretched period runs one index further
  assign last_idx   = swallow ? CW'(BASE) : CW'(BASE - 1);
  assign period_end = en & (cnt_q == last_idx);

  always_comb begin
    cnt_d = cnt_q;
    if (restart) begin
      cnt_d = '0;
    end else if (en) begin
      if (period_end) cnt_d = '0;
      else            cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(BASE)); // R2

endmodule

// File: rtl/fbdiv_swallow_ctr.sv
module fbdiv_swallow_ctr #(
  parameter int SWL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,      // cycle boundary
  input  logic [SWL_W-1:0] load_val,  // new swallow count
  input  logic             step,      // one prescaler period done
  output logic             swallow,   // current period is stretched
  output logic [SWL_W-1:0] a_left     // stretched periods still due
);

  logic [SWL_W-1:0] rem_q;
  logic [SWL_W-1:0] rem_d;

  assign swallow = (rem_q != '0);
  assign a_left  = rem_q;

  always_comb begin
    rem_d = rem_q;
    if (load) begin
      rem_d = load_val;
    end else if (step && swallow) begin
      rem_d = rem_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rem_q <= '0;
    else        rem_q <= rem_d;
  end

endmodule

// File: rtl/fbdiv_modulus_ctr.sv
module fbdiv_modulus_ctr #(
  parameter int MOD_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,        // a valid setting is active
  input  logic             load,       // cycle boundary: capture m_in
  input  logic [MOD_W-1:0] m_in,
  input  logic             step,       // one prescaler period done
  output logic             cycle_end,  // last input clock of the cycle
  output logic [MOD_W-1:0] m_cnt,      // periods completed in this cycle
  output logic [MOD_W-1:0] m_cfg       // captured period count
);

  logic [MOD_W-1:0] cnt_q, cnt_d;
  logic [MOD_W-1:0] cfg_q, cfg_d;

  assign cycle_end = run & step & (cnt_q == cfg_q - 1'b1);
  assign m_cnt     = cnt_q;
  assign m_cfg     = cfg_q;

  always_comb begin
    cnt_d = cnt_q;
    cfg_d = cfg_q;
    if (load) begin
      cnt_d = '0;
      cfg_d = m_in;
    end else if (step) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cfg_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      cfg_q <= cfg_d;
    end
  end

  AST_CNT_BELOW_M: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < cfg_q)); // R2

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cycle_end) |=> $stable(cfg_q)); // R6

endmodule

// File: rtl/fbdiv_dual_mod.sv
module fbdiv_dual_mod
  import fbdiv_pkg::*;
#(
  parameter int PRE_BASE = FB_PRE_BASE,
  parameter int MOD_W    = FB_MOD_W,
  parameter int SWL_W    = FB_SWL_W,
  parameter int SYNC_LEN = FB_SYNC_LEN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MOD_W-1:0] mod_m,
  input  logic [SWL_W-1:0] swl_a,
  output logic             fb_pulse,
  output logic             cfg_bad
);

  localparam int SUM_W = MOD_W + 1;

  logic             rst_sync_n;
  logic             period_end;
  logic             swallow;
  logic [SWL_W-1:0] a_left;
  logic             cycle_end;
  logic [MOD_W-1:0] m_cnt;
  logic [MOD_W-1:0] m_cfg;

  fb_state_e state_q, state_d;
  logic      bad_q, bad_d;
  logic      pulse_q, pulse_d;
  logic      running;
  logic      load;
  logic      cfg_ok;

  fbdiv_rst_sync #(.STAGES(SYNC_LEN)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // Setting check and boundary detection
  assign cfg_ok  = MOD_W'(swl_a) < mod_m;
  assign running = (state_q == FB_RUN);
  assign load    = !running || cycle_end;

  fbdiv_prescaler #(.BASE(PRE_BASE)) u_prescaler (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .en         (running),
    .restart    (load),
    .swallow    (swallow),
    .period_end (period_end)
  );

  fbdiv_swallow_ctr #(.SWL_W(SWL_W)) u_swallow (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (load),
    .load_val (swl_a),
    .step     (period_end),
    .swallow  (swallow),
    .a_left   (a_left)
  );

  fbdiv_modulus_ctr #(.MOD_W(MOD_W)) u_modulus (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .run       (running),
    .load      (load),
    .m_in      (mod_m),
    .step      (period_end),
    .cycle_end (cycle_end),
    .m_cnt     (m_cnt),
    .m_cfg     (m_cfg)
  );

  // Next state: decide run or idle at every boundary
  always_comb begin
    state_d = state_q;
    bad_d   = bad_q;
    pulse_d = cycle_end;
    if (load) begin
      state_d = cfg_ok ? FB_RUN : FB_IDLE;
      bad_d   = !cfg_ok;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= FB_IDLE;
      bad_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      state_q <= state_d;
      bad_q   <= bad_d;
      pulse_q <= pulse_d;
    end
  end

  assign fb_pulse = pulse_q;
  assign cfg_bad  = bad_q;

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_sync_n |-> (!pulse_q && !bad_q)); // R1

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pulse_q |=> !pulse_q); // R5

  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bad_q && $past(bad_q)) |-> !pulse_q); // R7

  AST_SWALLOW_FITS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    running |-> (SUM_W'(a_left) + SUM_W'(m_cnt) < SUM_W'(m_cfg))); // R2

endmodule

// File: tb/fbdiv_dual_mod_test.sv
module fbdiv_dual_mod_test;

  localparam int LIMIT = 5000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] mod_m = 8'd2;
  logic [2:0] swl_a = 3'd1;
  logic       fb_pulse;
  logic       cfg_bad;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  fbdiv_dual_mod uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .mod_m    (mod_m),
    .swl_a    (swl_a),
    .fb_pulse (fb_pulse),
    .cfg_bad  (cfg_bad)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Count negedges until the next pulse; note whether the first one was low
  task automatic measure(output int n, output bit low_after);
    n = 0;
    low_after = 1'b1;
    do begin
      @(negedge clk);
      n++;
      if (n == 1 && fb_pulse) low_after = 1'b0;
    end while (!fb_pulse && n < LIMIT);
  endtask

  task automatic t_reset();
    int n;
    bit low;
    repeat (4) @(negedge clk);
    check(fb_pulse == 1'b0, "R1 pulse in reset", int'(fb_pulse), 0);
    check(cfg_bad == 1'b0, "R1 flag in reset", int'(cfg_bad), 0);
    rst_n = 1'b1;
    measure(n, low);
    check(n == 20, "R1 first pulse latency", n, 20);
  endtask

  // Called at a pulse: apply new values, old interval first, then new one
  task automatic t_interval(input int m, input int a, input int prev, input string req);
    int n;
    bit low;
    mod_m = 8'(m);
    swl_a = 3'(a);
    measure(n, low);
    check(n == prev, "R6 running cycle keeps old length", n, prev);
    check(low, "R5 pulse width", int'(!low), 0);
    measure(n, low);
    check(n == m * 8 + a, req, n, m * 8 + a);
  endtask

  task automatic t_midcycle();
    int n;
    bit low;
    repeat (3) @(negedge clk);
    mod_m = 8'd3;
    swl_a = 3'd2;
    measure(n, low);
    check(n + 3 == 8, "R6 mid-cycle change deferred", n + 3, 8);
    measure(n, low);
    check(n == 26, "R6 new setting next cycle", n, 26);
  endtask

  task automatic t_invalid();
    int n;
    bit low;
    bit seen;
    mod_m = 8'd3;
    swl_a = 3'd3;
    measure(n, low);
    check(n == 26, "R6 cycle before invalid setting", n, 26);
    check(cfg_bad == 1'b1, "R7 flag with last pulse", int'(cfg_bad), 1);
    check(fb_pulse == 1'b1, "R7 last pulse still emitted", int'(fb_pulse), 1);
    seen = 1'b0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (fb_pulse) seen = 1'b1;
    end
    check(!seen, "R7 output held low", int'(seen), 0);
    check(cfg_bad == 1'b1, "R7 flag held", int'(cfg_bad), 1);
    mod_m = 8'd0;
    swl_a = 3'd0;
    repeat (3) @(negedge clk);
    check(cfg_bad == 1'b1, "R7 M=0 rejected", int'(cfg_bad), 1);
    check(fb_pulse == 1'b0, "R7 no pulse with M=0", int'(fb_pulse), 0);
    mod_m = 8'd1;
    @(negedge clk);
    check(cfg_bad == 1'b0, "R7 flag clears", int'(cfg_bad), 0);
    measure(n, low);
    check(n == 8, "R7 recovery latency", n, 8);
    measure(n, low);
    check(n == 8, "R8 recovered interval", n, 8);
  endtask

  initial begin
    t_reset();
    t_interval(5, 0, 17, "R3 A=0 modulus");
    t_interval(6, 1, 40, "R4 A=1 modulus");
    t_interval(8, 7, 49, "R2 A=7 modulus");
    t_interval(100, 3, 71, "R2 mid-range modulus");
    t_interval(255, 7, 803, "R8 largest modulus");
    t_interval(1, 0, 2047, "R8 smallest modulus");
    t_midcycle();
    t_invalid();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  // Watchdog
  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !done) begin
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

endmodule